// File: doc/BRIEF.md
# Fault-Triggered Extremum Capture Unit

This block samples a free-running counter value into a capture register each time a fault event arrives. A three-bit mode input selects how the sample is used. The register can be loaded with every sample, or it can be updated only when a new absolute minimum or maximum is seen. In the local modes it follows every sample while a separate history register tracks the previous sample, so that turning points can be detected. The timer that produces the counter and top values is outside this block.

Each qualifying result raises a one-cycle interrupt pulse and sets a sticky match flag. In plain capture mode every event qualifies. In the other modes only an extreme qualifies. A preload write seeds the capture register with a starting value, clears the flag and empties the history. The absolute modes depend on that preload, because a register that holds 0 (minimum mode) or the top value (maximum mode) never captures.

The history logic is a two-state machine. HIST_EMPTY means no previous sample is held. HIST_HELD means one is held. The transitions are:
- PRIME: a local-mode event moves HIST_EMPTY to HIST_HELD.
- REARM: a preload write moves HIST_HELD to HIST_EMPTY. A mode change without a local-mode event does the same.
- REPRIME: a local-mode event in the same cycle as a mode change keeps HIST_HELD. The event reloads the history but raises nothing.

Top module: `fault_extremum_capture`

## Requirements
- R1: After reset, cap_o is 0, flag_o is 0, irq_o is 0 and the history is empty.
- R2: In mode 0 (plain), each event loads cnt_i into cap_o and raises irq_o.
- R3: In mode 1 (absolute minimum), an event loads cnt_i only when cnt_i is strictly below cap_o. Each such load raises irq_o, and an event with no load raises nothing.
- R4: In mode 2 (absolute maximum), an event loads cnt_i only when cnt_i is strictly above cap_o. Each such load raises irq_o, and an event with no load raises nothing.
- R5: In mode 1 with cap_o equal to 0, and in mode 2 with cap_o equal to top_i, events neither capture nor raise irq_o.
- R6: In modes 3, 4 and 5 (local), every event loads cnt_i into cap_o. The first event after reset, after a preload write or in a cycle where the mode differs from the previous cycle only loads the history and raises no irq_o.
- R7: With a history held, mode 3 raises irq_o when cnt_i is greater than or equal to the previous sample. Mode 4 raises irq_o when cnt_i is less than or equal to the previous sample.
- R8: With a history held, mode 5 raises irq_o when either the mode 3 condition or the mode 4 condition holds.
- R9: irq_o is high for exactly the one cycle after a qualifying event. flag_o is set in that same cycle and stays set until a preload write.
- R10: A preload write loads pre_val_i into cap_o, clears flag_o and empties the history. An event in the same cycle is dropped.
- R11: In modes 6 and 7, events change nothing and raise nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_i | input | CW | Counter value sampled on an event |
| top_i | input | CW | Counter top value, used by the maximum lock |
| evt_i | input | 1 | Fault event, one per cycle high |
| mode_i | input | 3 | Capture mode, 0 to 5, 6 and 7 inert |
| pre_we_i | input | 1 | Preload write strobe |
| pre_val_i | input | CW | Preload value |
| cap_o | output | CW | Capture register |
| flag_o | output | 1 | Sticky match flag |
| irq_o | output | 1 | One-cycle interrupt/event pulse |

## Verification
Two operations can land on the same clock edge. The first collision is a preload write with an event. The bench drives both in one cycle in plain and local modes and checks that cap_o takes the preload value, that no pulse appears, and that the next local event only primes the history. The second collision is a mode change with an event. The bench switches between local modes on the very cycle of an event and checks that this event reloads the history silently, while the following event is judged against it.

// File: rtl/fec_pkg.sv
package fec_pkg;
    localparam logic [2:0] MODE_PLAIN   = 3'd0;
    localparam logic [2:0] MODE_ABS_MIN = 3'd1;
    localparam logic [2:0] MODE_ABS_MAX = 3'd2;
    localparam logic [2:0] MODE_LOC_MIN = 3'd3;
    localparam logic [2:0] MODE_LOC_MAX = 3'd4;
    localparam logic [2:0] MODE_LOC_ANY = 3'd5;

    typedef enum logic {
        HIST_EMPTY = 1'b0,
        HIST_HELD  = 1'b1
    } hist_state_e;
endpackage

// File: rtl/fec_judge.sv
module fec_judge
    import fec_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic [2:0]    mode,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] top,
    input  logic [CW-1:0] cap,
    input  logic [CW-1:0] prev,
    output logic          take,
    output logic          hit,
    output logic          is_local
);
    logic ge_prev, le_prev;

    assign ge_prev = (cnt >= prev);
    assign le_prev = (cnt <= prev);

    always_comb begin
        take     = 1'b0;
        hit      = 1'b0;
        is_local = 1'b0;
        unique case (mode)
            MODE_PLAIN: begin
                take = 1'b1;
                hit  = 1'b1;
            end
            MODE_ABS_MIN: begin
                take = (cap != '0) && (cnt < cap);
                hit  = take;
            end
            MODE_ABS_MAX: begin
                take = (cap != top) && (cnt > cap);
                hit  = take;
            end
            MODE_LOC_MIN: begin
                take     = 1'b1;
                hit      = ge_prev;
                is_local = 1'b1;
            end
            MODE_LOC_MAX: begin
                take     = 1'b1;
                hit      = le_prev;
                is_local = 1'b1;
            end
            MODE_LOC_ANY: begin
                take     = 1'b1;
                hit      = ge_prev | le_prev;
                is_local = 1'b1;
            end
            default: begin
                take = 1'b0;
                hit  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fec_history_fsm.sv
module fec_history_fsm
    import fec_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    mode,
    input  logic          evt_ok,
    input  logic          is_local,
    input  logic          preload,
    input  logic [CW-1:0] cnt,
    output logic [CW-1:0] prev,
    output logic          tracking
);
    hist_state_e state_q, state_d;
    logic [2:0]  mode_q;
    logic        mode_chg;
    logic        local_evt;

    assign mode_chg  = (mode != mode_q);
    assign local_evt = evt_ok & is_local;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            HIST_EMPTY: if (local_evt)                       state_d = HIST_HELD;
            HIST_HELD:  if ((preload | mode_chg) && !local_evt) state_d = HIST_EMPTY;
            default:                                          state_d = HIST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HIST_EMPTY;
            mode_q  <= '0;
        end else begin
            state_q <= state_d;
            mode_q  <= mode;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)         prev <= '0;
        else if (local_evt) prev <= cnt;
    end

    assign tracking = (state_q == HIST_HELD) && !mode_chg;
endmodule

// File: rtl/fault_extremum_capture.sv
module fault_extremum_capture
    import fec_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] top_i,
    input  logic          evt_i,
    input  logic [2:0]    mode_i,
    input  logic          pre_we_i,
    input  logic [CW-1:0] pre_val_i,
    output logic [CW-1:0] cap_o,
    output logic          flag_o,
    output logic          irq_o
);
    logic          take, hit, is_local, tracking, evt_ok, qual;
    logic [CW-1:0] prev;

    assign evt_ok = evt_i & ~pre_we_i;

    fec_judge #(.CW(CW)) u_judge (
        .mode     (mode_i),
        .cnt      (cnt_i),
        .top      (top_i),
        .cap      (cap_o),
        .prev     (prev),
        .take     (take),
        .hit      (hit),
        .is_local (is_local)
    );

    fec_history_fsm #(.CW(CW)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode_i),
        .evt_ok   (evt_ok),
        .is_local (is_local),
        .preload  (pre_we_i),
        .cnt      (cnt_i),
        .prev     (prev),
        .tracking (tracking)
    );

    assign qual = evt_ok & hit & (~is_local | tracking);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_o  <= '0;
            flag_o <= 1'b0;
            irq_o  <= 1'b0;
        end else begin
            irq_o <= qual;
            if (pre_we_i) begin
                cap_o  <= pre_val_i;
                flag_o <= 1'b0;
            end else begin
                if (evt_ok && take) cap_o  <= cnt_i;
                if (qual)           flag_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fec_checker.sv
module fec_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] cnt_i,
    input logic [CW-1:0] top_i,
    input logic          evt_i,
    input logic [2:0]    mode_i,
    input logic          pre_we_i,
    input logic [CW-1:0] pre_val_i,
    input logic [CW-1:0] cap_o,
    input logic          flag_o,
    input logic          irq_o
);
    logic is_loc;
    assign is_loc = (mode_i == 3'd3) || (mode_i == 3'd4) || (mode_i == 3'd5);

    assert_plain_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i && !pre_we_i && mode_i == 3'd0 |=> cap_o == $past(cnt_i) && irq_o);

    assert_min_never_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i && !pre_we_i && mode_i == 3'd1 |=> cap_o <= $past(cap_o));

    assert_max_never_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i && !pre_we_i && mode_i == 3'd2 |=> cap_o >= $past(cap_o));

    assert_max_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i && !pre_we_i && mode_i == 3'd2 && cap_o == top_i |=> $stable(cap_o) && !irq_o);

    assert_local_prime_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i && !pre_we_i && is_loc && mode_i != $past(mode_i) |=> !irq_o && cap_o == $past(cnt_i));

    assert_irq_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flag_o && !pre_we_i |=> flag_o);

    assert_preload_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pre_we_i |=> cap_o == $past(pre_val_i) && !flag_o && !irq_o);

    assert_reserved_inert_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_we_i && mode_i[2:1] == 2'b11 |=> $stable(cap_o) && !irq_o);
endmodule

bind fault_extremum_capture fec_checker #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_i     (cnt_i),
    .top_i     (top_i),
    .evt_i     (evt_i),
    .mode_i    (mode_i),
    .pre_we_i  (pre_we_i),
    .pre_val_i (pre_val_i),
    .cap_o     (cap_o),
    .flag_o    (flag_o),
    .irq_o     (irq_o)
);

// File: tb/sim_fault_extremum_capture.sv
module sim_fault_extremum_capture;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cnt_i = '0, top_i = '0, pre_val_i = '0, cap_o;
    logic          evt_i = 1'b0, pre_we_i = 1'b0, flag_o, irq_o;
    logic [2:0]    mode_i = '0;

    int checks = 0;
    int failures = 0;
    string cur_req = "R1";

    int  m_cap = 0, m_prev = 0, m_mode = 0;
    bit  m_flag = 0, m_irq = 0, m_primed = 0;

    always #2.5 clk = ~clk;

    fault_extremum_capture #(.CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .top_i(top_i), .evt_i(evt_i),
        .mode_i(mode_i), .pre_we_i(pre_we_i), .pre_val_i(pre_val_i),
        .cap_o(cap_o), .flag_o(flag_o), .irq_o(irq_o)
    );

    task automatic compare();
        checks++;
        if (int'(cap_o) != m_cap || flag_o != m_flag || irq_o != m_irq) begin
            failures++;
            $display("FAIL %s: cap=%0d flag=%0b irq=%0b expected cap=%0d flag=%0b irq=%0b",
                     cur_req, cap_o, flag_o, irq_o, m_cap, m_flag, m_irq);
        end
    endtask

    task automatic model(int cnt, int top, bit evt, int mode, bit pl, int plv);
        bit chg = (mode != m_mode);
        bit h = 0;
        m_irq = 0;
        if (pl) begin
            m_cap = plv; m_flag = 0; m_primed = 0;
        end else begin
            if (evt && mode == 0) begin
                m_cap = cnt; h = 1;
            end else if (evt && mode == 1) begin
                if (m_cap != 0 && cnt < m_cap) begin m_cap = cnt; h = 1; end
            end else if (evt && mode == 2) begin
                if (m_cap != top && cnt > m_cap) begin m_cap = cnt; h = 1; end
            end else if (evt && mode >= 3 && mode <= 5) begin
                if (m_primed && !chg) begin
                    if (mode == 3) h = (cnt >= m_prev);
                    else if (mode == 4) h = (cnt <= m_prev);
                    else h = (cnt >= m_prev) || (cnt <= m_prev);
                end
                m_cap = cnt; m_prev = cnt; m_primed = 1;
            end
            if (chg && !(evt && mode >= 3 && mode <= 5)) m_primed = 0;
            if (h) begin m_flag = 1; m_irq = 1; end
        end
        m_mode = mode;
    endtask

    task automatic tick(int cnt, bit evt, int mode, bit pl = 0, int plv = 0, int top = 500);
        cnt_i = CW'(cnt); evt_i = evt; mode_i = 3'(mode);
        pre_we_i = pl; pre_val_i = CW'(plv); top_i = CW'(top);
        @(posedge clk);
        model(cnt, top, evt, mode, pl, plv);
        @(negedge clk);
        compare();
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R1"; compare();

        cur_req = "R2";
        tick(100, 1, 0); tick(50, 1, 0); tick(7, 0, 0); tick(300, 1, 0);

        cur_req = "R10";
        tick(0, 0, 1, 1, 1000);
        cur_req = "R3";
        tick(800, 1, 1); tick(900, 1, 1); tick(800, 1, 1); tick(0, 0, 1); tick(10, 1, 1);

        cur_req = "R5";
        tick(0, 0, 1, 1, 0); tick(5, 1, 1); tick(3, 1, 1);
        tick(0, 0, 2, 1, 500); tick(600, 1, 2); tick(900, 1, 2);

        cur_req = "R4";
        tick(0, 0, 2, 1, 100); tick(200, 1, 2); tick(150, 1, 2); tick(200, 1, 2); tick(400, 1, 2);

        cur_req = "R6";
        tick(50, 1, 3);
        cur_req = "R7";
        tick(60, 1, 3); tick(40, 1, 3); tick(40, 1, 3); tick(0, 0, 3);
        cur_req = "R6";
        tick(70, 1, 4);
        cur_req = "R7";
        tick(30, 1, 4); tick(90, 1, 4); tick(90, 1, 4);

        cur_req = "R9";
        tick(0, 0, 4); tick(0, 0, 4);
        cur_req = "R10";
        tick(0, 0, 4, 1, 77);

        cur_req = "R6";
        tick(0, 0, 5); tick(10, 1, 5);
        cur_req = "R8";
        tick(20, 1, 5); tick(5, 1, 5); tick(5, 1, 5);

        cur_req = "R10";
        tick(123, 1, 0, 1, 999); tick(0, 0, 3); tick(15, 1, 3, 1, 44); tick(16, 1, 3);
        cur_req = "R7";
        tick(17, 1, 3);

        cur_req = "R11";
        tick(222, 1, 6); tick(333, 1, 7); tick(0, 0, 7);

        cur_req = "R2";
        tick(444, 1, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule